// File: doc/BRIEF.md
# Multiplexed LCD Row Scan and Drive Level Selector

This block produces the row-scan timing for a 65-line multiplexed dot-matrix display. Each pulse of the display clock enable moves the scan forward by one line. The block then requests the matching row from display RAM and latches that row when it arrives. From the latched row it derives the drive level for every common and segment electrode. Levels are given as 2-bit codes, and a later analog stage turns each code into a voltage. An alternating polarity signal stops a DC voltage from building up across the liquid crystal. The polarity can flip once per frame, or once every N scanned lines.

A scan covers 65 line slots. The first 64 slots read RAM starting at a programmable start line, with the line address going up and wrapping modulo 64. Changing the start line scrolls the picture. The 65th slot always reads the fixed indicator row, whatever the start line. Several controls act only on the latched row and never touch RAM: the scan direction of the 64 main commons, normal or reverse video, and display on/off.

Row data comes in through a valid/ready handshake. `row_ready` rises on the clock edge that samples a display tick, and it stays high until a row is accepted, for as long as RAM takes. A row is accepted on an edge where `row_valid` and `row_ready` are both high. `row_valid` has no effect while `row_ready` is low. If a tick and an acceptance fall on the same edge, the row is latched for the previous line and `row_ready` stays high for the new one.

Top module: `lcd_scan_drive`

## Requirements
- R1: After reset, `line_addr` equals `start_line`, `row_ready` is 1, `fr` is 0, and every bit of `com_sel`, `com_lvl` and `seg_lvl` is 0.
- R2: The scan position p counts display ticks from 0 to 64 and then wraps to 0. For p below 64, `line_addr` is (start_line + p) mod 64, and it is valid from the edge that samples the tick.
- R3: At p = 64, `line_addr` is 64 (the indicator row), whatever the start line.
- R4: `com_sel` is one-hot for the latched line and all zero when blanked. For a main line p, the selected bit is p in forward scan (`scan_rev`=0) and 63-p in reversed scan. For the indicator line, bit 64 is selected in both directions.
- R5: In frame inversion mode (`line_inv_mode`=0), polarity toggles on the tick that moves p from 64 to 0.
- R6: In line inversion mode (`line_inv_mode`=1), polarity toggles every N ticks, where N = `line_inv_len` + 1 (1 to 32). The line counter starts at 0 on entry to the mode.
- R7: Segment j has code 11 (V1) for data 1 with `fr`=1, code 00 (VSS) for data 1 with `fr`=0, code 10 (V3) for data 0 with `fr`=1, and code 01 (V4) for data 0 with `fr`=0. Segment j occupies `seg_lvl[2j+1:2j]`, and its data is bit j of the latched row.
- R8: With `rev_video`=1, the data sense of every segment is inverted before the level choice in R7.
- R9: Common i occupies `com_lvl[2i+1:2i]`. A selected common has code 00 (VSS) when `fr`=1 and 11 (V1) when `fr`=0. An unselected common has code 10 (V2) when `fr`=1 and 01 (V5) when `fr`=0.
- R10: While `disp_on`=0, and before the first row has been accepted, all level codes are 00 and `com_sel` is 0. Setting `disp_on` back to 1 shows the latched row again, with no new row transfer.
- R11: A row is accepted when `row_valid` and `row_ready` are both high. `row_ready` then falls unless a tick is sampled on the same edge. `row_valid` has no effect while `row_ready` is low. The outputs and `fr` show the accepted row, its line and its polarity from that edge onward, and `fr` changes only on an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_tick | input | 1 | Display clock enable, one pulse per scanned line |
| start_line | input | 6 | First RAM line shown in the scan |
| scan_rev | input | 1 | 1 reverses the scan direction of the 64 main commons |
| rev_video | input | 1 | 1 inverts the pixel sense |
| disp_on | input | 1 | 0 forces every output to VSS |
| line_inv_mode | input | 1 | 0 selects frame inversion, 1 selects line inversion |
| line_inv_len | input | 5 | Lines per polarity period minus one, in line inversion mode |
| row_data | input | 132 | Row read from display RAM at `line_addr` |
| row_valid | input | 1 | `row_data` is valid |
| row_ready | output | 1 | The block is waiting for a row |
| line_addr | output | 7 | RAM line to read, 0 to 64 |
| fr | output | 1 | Polarity of the displayed line |
| com_sel | output | 65 | One-hot common selection |
| com_lvl | output | 130 | 2-bit level code per common |
| seg_lvl | output | 264 | 2-bit level code per segment |

## Verification
`line_addr` follows from the tick one edge later. The bench sets the tick on a falling edge and reads the address on the next falling edge. The level codes, `com_sel` and `fr` change on the edge that accepts a row. The driver pushes each expected item, tagged with the cycle after its `row_valid` cycle, and the monitor compares it one nanosecond after that falling edge. Controls applied to the latched row act combinationally. Their checks are therefore due one cycle after the control changes, and no new row is sent for them.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam logic [1:0] LV_GND = 2'b00;  // VSS
  localparam logic [1:0] LV_LOW = 2'b01;  // V4 or V5
  localparam logic [1:0] LV_MID = 2'b10;  // V2 or V3
  localparam logic [1:0] LV_TOP = 2'b11;  // V1

  // Segment electrode level from effective pixel and polarity.
  function automatic logic [1:0] seg_level(input logic pix, input logic pol);
    if (pol) return pix ? LV_TOP : LV_MID;
    else     return pix ? LV_GND : LV_LOW;
  endfunction

  // Common electrode level from selection and polarity.
  function automatic logic [1:0] com_level(input logic sel, input logic pol);
    if (pol) return sel ? LV_GND : LV_MID;
    else     return sel ? LV_TOP : LV_LOW;
  endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int NLINES = 64,
  parameter int INV_W  = 5,
  localparam int LINE_W = $clog2(NLINES),
  localparam int ADDR_W = LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LINE_W-1:0] start_line,
  input  logic              line_inv_mode,
  input  logic [INV_W-1:0]  line_inv_len,
  output logic [ADDR_W-1:0] phase,
  output logic              pol,
  output logic [ADDR_W-1:0] line_addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NLINES);

  logic [INV_W-1:0] inv_cnt;
  logic             at_last;

  assign at_last = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      pol     <= 1'b0;
      inv_cnt <= '0;
    end else if (tick) begin
      phase <= at_last ? '0 : phase + 1'b1;
      if (line_inv_mode) begin
        if (inv_cnt >= line_inv_len) begin
          pol     <= ~pol;
          inv_cnt <= '0;
        end else begin
          inv_cnt <= inv_cnt + 1'b1;
        end
      end else begin
        inv_cnt <= '0;
        if (at_last) pol <= ~pol;
      end
    end
  end

  // Main lines wrap modulo NLINES; the indicator slot has a fixed address.
  assign line_addr = at_last ? LAST : {1'b0, start_line + phase[LINE_W-1:0]};

endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch #(
  parameter int NSEG   = 132,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              row_valid,
  input  logic [NSEG-1:0]   row_data,
  input  logic [ADDR_W-1:0] phase,
  input  logic              pol,
  output logic              row_ready,
  output logic [NSEG-1:0]   lat_row,
  output logic [ADDR_W-1:0] lat_ph,
  output logic              lat_pol,
  output logic              lat_vld
);

  logic accept;
  assign accept = row_valid && row_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_ready <= 1'b1;
      lat_row   <= '0;
      lat_ph    <= '0;
      lat_pol   <= 1'b0;
      lat_vld   <= 1'b0;
    end else begin
      if (accept) begin
        lat_row <= row_data;
        lat_ph  <= phase;
        lat_pol <= pol;
        lat_vld <= 1'b1;
      end
      if (tick)        row_ready <= 1'b1;
      else if (accept) row_ready <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_scan_pkg::*;
#(
  parameter int NLINES = 64,
  parameter int ADDR_W = 7,
  localparam int NCOM  = NLINES + 1
) (
  input  logic [ADDR_W-1:0] lat_ph,
  input  logic              lat_pol,
  input  logic              scan_rev,
  input  logic              active,
  output logic [NCOM-1:0]   com_sel,
  output logic [2*NCOM-1:0] com_lvl
);

  localparam logic [ADDR_W-1:0] IND = ADDR_W'(NLINES);

  logic on_ind;
  assign on_ind = (lat_ph == IND);

  for (genvar i = 0; i < NCOM; i++) begin : g_com
    logic hit;
    if (i == NLINES) begin : g_ind
      assign hit = on_ind;
    end else begin : g_main
      localparam logic [ADDR_W-1:0] FWD = ADDR_W'(i);
      localparam logic [ADDR_W-1:0] BWD = ADDR_W'(NLINES - 1 - i);
      assign hit = !on_ind && (scan_rev ? (lat_ph == BWD) : (lat_ph == FWD));
    end
    assign com_sel[i]         = active && hit;
    assign com_lvl[2*i +: 2]  = active ? com_level(hit, lat_pol) : LV_GND;
  end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_scan_pkg::*;
#(
  parameter int NSEG = 132
) (
  input  logic [NSEG-1:0]   lat_row,
  input  logic              lat_pol,
  input  logic              rev_video,
  input  logic              active,
  output logic [2*NSEG-1:0] seg_lvl
);

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    logic pix;
    assign pix               = lat_row[j] ^ rev_video;
    assign seg_lvl[2*j +: 2] = active ? seg_level(pix, lat_pol) : LV_GND;
  end

endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive #(
  parameter int NSEG   = 132,
  parameter int NLINES = 64,
  parameter int INV_W  = 5,
  localparam int LINE_W = $clog2(NLINES),
  localparam int ADDR_W = LINE_W + 1,
  localparam int NCOM   = NLINES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_tick,
  input  logic [LINE_W-1:0] start_line,
  input  logic              scan_rev,
  input  logic              rev_video,
  input  logic              disp_on,
  input  logic              line_inv_mode,
  input  logic [INV_W-1:0]  line_inv_len,
  input  logic [NSEG-1:0]   row_data,
  input  logic              row_valid,
  output logic              row_ready,
  output logic [ADDR_W-1:0] line_addr,
  output logic              fr,
  output logic [NCOM-1:0]   com_sel,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl
);

  logic [ADDR_W-1:0] phase, lat_ph;
  logic              pol, lat_pol, lat_vld, active;
  logic [NSEG-1:0]   lat_row;

  lcd_scan_timer #(.NLINES(NLINES), .INV_W(INV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(disp_tick), .start_line(start_line),
    .line_inv_mode(line_inv_mode), .line_inv_len(line_inv_len),
    .phase(phase), .pol(pol), .line_addr(line_addr)
  );

  lcd_row_latch #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .tick(disp_tick), .row_valid(row_valid),
    .row_data(row_data), .phase(phase), .pol(pol), .row_ready(row_ready),
    .lat_row(lat_row), .lat_ph(lat_ph), .lat_pol(lat_pol), .lat_vld(lat_vld)
  );

  assign active = disp_on && lat_vld;
  assign fr     = lat_pol;

  lcd_com_drive #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_com (
    .lat_ph(lat_ph), .lat_pol(lat_pol), .scan_rev(scan_rev), .active(active),
    .com_sel(com_sel), .com_lvl(com_lvl)
  );

  lcd_seg_drive #(.NSEG(NSEG)) u_seg (
    .lat_row(lat_row), .lat_pol(lat_pol), .rev_video(rev_video),
    .active(active), .seg_lvl(seg_lvl)
  );

endmodule

// File: rtl/lcd_scan_drive_chk.sv
module lcd_scan_drive_chk #(
  parameter int NSEG   = 132,
  parameter int NLINES = 64,
  parameter int INV_W  = 5,
  localparam int LINE_W = $clog2(NLINES),
  localparam int ADDR_W = LINE_W + 1,
  localparam int NCOM   = NLINES + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_tick,
  input logic [LINE_W-1:0] start_line,
  input logic              disp_on,
  input logic              row_valid,
  input logic              row_ready,
  input logic [ADDR_W-1:0] line_addr,
  input logic              fr,
  input logic [NCOM-1:0]   com_sel,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [2*NSEG-1:0] seg_lvl
);

  a_r4_com_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));

  a_r10_blank_out: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (seg_lvl == '0 && com_lvl == '0 && com_sel == '0));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_tick |=> (line_addr == $past(line_addr) || start_line != $past(start_line)));

  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_addr <= ADDR_W'(NLINES));

  a_r11_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    disp_tick |=> row_ready);

  a_r11_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_ready && !disp_tick) |=> !row_ready);

  a_r11_fr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_valid && row_ready) |=> $stable(fr));

  a_r9_ind_level: assert property (@(posedge clk) disable iff (!rst_n)
    com_sel[NLINES] |-> (com_lvl[2*NLINES +: 2] == (fr ? 2'b00 : 2'b11)));

endmodule

bind lcd_scan_drive lcd_scan_drive_chk #(.NSEG(NSEG), .NLINES(NLINES), .INV_W(INV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_tick(disp_tick), .start_line(start_line),
  .disp_on(disp_on), .row_valid(row_valid), .row_ready(row_ready),
  .line_addr(line_addr), .fr(fr), .com_sel(com_sel), .com_lvl(com_lvl),
  .seg_lvl(seg_lvl)
);

// File: tb/lcd_scan_drive_test.sv
module lcd_scan_drive_test;

  localparam int NSEG = 132;
  localparam int NL   = 64;
  localparam int NCOM = NL + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_tick = 1'b0;
  logic [5:0] start_line = '0;
  logic scan_rev = 1'b0, rev_video = 1'b0, disp_on = 1'b1;
  logic line_inv_mode = 1'b0;
  logic [4:0] line_inv_len = '0;
  logic [NSEG-1:0] row_data = '0;
  logic row_valid = 1'b0;
  logic row_ready, fr;
  logic [6:0] line_addr;
  logic [NCOM-1:0] com_sel;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  lcd_scan_drive uut (
    .clk(clk), .rst_n(rst_n), .disp_tick(disp_tick), .start_line(start_line),
    .scan_rev(scan_rev), .rev_video(rev_video), .disp_on(disp_on),
    .line_inv_mode(line_inv_mode), .line_inv_len(line_inv_len),
    .row_data(row_data), .row_valid(row_valid), .row_ready(row_ready),
    .line_addr(line_addr), .fr(fr), .com_sel(com_sel), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0]        due;
    logic               f;
    logic [NCOM-1:0]    csel;
    logic [2*NCOM-1:0]  clvl;
    logic [2*NSEG-1:0]  slvl;
  } item_t;

  item_t sbq[$];
  string tagq[$];

  // Reference scan model
  int bm_ph = 0, bm_cnt = 0;
  logic bm_fr = 1'b0;
  // Reference latched state
  int lt_ph = 0;
  logic lt_fr = 1'b0, lt_vld = 1'b0;
  logic [NSEG-1:0] lt_row = '0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [NSEG-1:0] pat(input int k);
    logic [NSEG-1:0] v;
    for (int j = 0; j < NSEG; j++) v[j] = (((j * 5 + k * 3) % 7) < 3);
    return v;
  endfunction

  function automatic logic [6:0] exp_addr();
    if (bm_ph == NL) return 7'd64;
    return 7'((int'(start_line) + bm_ph) % NL);
  endfunction

  function automatic item_t expect_now();
    item_t it;
    logic act, pix;
    int idx;
    act = disp_on && lt_vld;
    idx = (lt_ph == NL) ? NL : (scan_rev ? NL - 1 - lt_ph : lt_ph);
    it.due = 32'(cyc + 1);
    it.f = lt_fr;
    for (int i = 0; i < NCOM; i++) begin
      it.csel[i] = act && (i == idx);
      if (!act)          it.clvl[2*i +: 2] = 2'b00;
      else if (i == idx) it.clvl[2*i +: 2] = lt_fr ? 2'b00 : 2'b11;
      else               it.clvl[2*i +: 2] = lt_fr ? 2'b10 : 2'b01;
    end
    for (int j = 0; j < NSEG; j++) begin
      pix = lt_row[j] ^ rev_video;
      if (!act)       it.slvl[2*j +: 2] = 2'b00;
      else if (lt_fr) it.slvl[2*j +: 2] = pix ? 2'b11 : 2'b10;
      else            it.slvl[2*j +: 2] = pix ? 2'b00 : 2'b01;
    end
    return it;
  endfunction

  task automatic push(input string tag);
    sbq.push_back(expect_now());
    tagq.push_back(tag);
  endtask

  // Monitor: compares queued expectations at their due cycle.
  always @(negedge clk) begin
    #1;
    if (sbq.size() > 0 && sbq[0].due == 32'(cyc)) begin
      item_t it;
      string tg;
      it = sbq.pop_front();
      tg = tagq.pop_front();
      chk(com_sel == it.csel, $sformatf("%s com_sel act=%h exp=%h", tg, com_sel, it.csel));
      chk(com_lvl == it.clvl, $sformatf("%s com_lvl act=%h exp=%h", tg, com_lvl, it.clvl));
      chk(seg_lvl == it.slvl, $sformatf("%s seg_lvl act=%h exp=%h", tg, seg_lvl, it.slvl));
      chk(fr == it.f, $sformatf("%s fr act=%0b exp=%0b", tg, fr, it.f));
    end
  end

  task automatic model_tick();
    if (line_inv_mode) begin
      if (bm_cnt >= int'(line_inv_len)) begin bm_fr = ~bm_fr; bm_cnt = 0; end
      else bm_cnt++;
    end else begin
      bm_cnt = 0;
      if (bm_ph == NL) bm_fr = ~bm_fr;
    end
    bm_ph = (bm_ph == NL) ? 0 : bm_ph + 1;
  endtask

  // Deliver a row for the current line (assumes row_ready)
  task automatic feed(input logic [NSEG-1:0] d, input string tag);
    row_data = d;
    row_valid = 1'b1;
    lt_row = d; lt_ph = bm_ph; lt_fr = bm_fr; lt_vld = 1'b1;
    push(tag);
    @(negedge clk);
    row_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic line_step(input string tag);
    disp_tick = 1'b1;
    @(negedge clk);
    disp_tick = 1'b0;
    model_tick();
    chk(line_addr == exp_addr(),
        $sformatf("%s line_addr p=%0d act=%0d exp=%0d", tag, bm_ph, line_addr, exp_addr()));
    chk(row_ready == 1'b1, $sformatf("R11 ready after tick act=%0b exp=1", row_ready));
    feed(pat(bm_ph + int'(start_line)), tag);
  endtask

  task automatic ctrl_check(input string tag);
    push(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(line_addr == 7'd0, $sformatf("R1 line_addr act=%0d exp=0", line_addr));
    chk(row_ready == 1'b1, $sformatf("R1 row_ready act=%0b exp=1", row_ready));
    chk(fr == 1'b0, $sformatf("R1 fr act=%0b exp=0", fr));
    chk(com_sel == '0 && com_lvl == '0 && seg_lvl == '0,
        $sformatf("R1 outputs act=%h/%h exp=0", com_sel, seg_lvl));

    // R10 blank before first row, R11 first accept
    ctrl_check("R10 before first row");
    feed(pat(0), "R7 first row p0");

    // R2 R5 R7 R9: frame mode, forward, start 0, just past two frame wraps
    for (int k = 0; k < 2 * NCOM + 2; k++) line_step("R2 R5 R7 R9 frame fwd");
    chk(bm_fr == 1'b0 && fr == 1'b0, $sformatf("R5 fr after two frames act=%0b exp=0", fr));

    // R2 R3 R4: wrap of address with start 60, reversed scan
    start_line = 6'd60;
    scan_rev = 1'b1;
    @(negedge clk);
    chk(line_addr == exp_addr(), $sformatf("R2 addr on start change act=%0d exp=%0d", line_addr, exp_addr()));
    for (int k = 0; k < NCOM + 3; k++) line_step("R3 R4 rev scan start60");

    // R8 reverse video on latched row, then streaming
    rev_video = 1'b1;
    ctrl_check("R8 rev_video on latched row");
    for (int k = 0; k < 5; k++) line_step("R8 rev video lines");
    rev_video = 1'b0;
    scan_rev = 1'b0;
    start_line = 6'd17;

    // R6 line inversion, N=3, N=1, N=32
    line_inv_mode = 1'b1;
    line_inv_len = 5'd2;
    for (int k = 0; k < 10; k++) line_step("R6 line inv N3");
    line_inv_len = 5'd0;
    for (int k = 0; k < 4; k++) line_step("R6 line inv N1");
    line_inv_mode = 1'b0;
    @(negedge clk);
    line_inv_mode = 1'b1;
    line_inv_len = 5'd31;
    for (int k = 0; k < 70; k++) line_step("R6 line inv N32");
    line_inv_mode = 1'b0;

    // R10 display off then on, with no new row
    disp_on = 1'b0;
    ctrl_check("R10 display off");
    disp_on = 1'b1;
    ctrl_check("R10 display on restores latch");

    // R11 back-pressure: tick, then RAM slow for 4 cycles
    disp_tick = 1'b1;
    @(negedge clk);
    disp_tick = 1'b0;
    model_tick();
    for (int k = 0; k < 4; k++) begin
      chk(row_ready == 1'b1, $sformatf("R11 ready held act=%0b exp=1", row_ready));
      ctrl_check("R11 output holds while waiting");
    end
    feed(pat(99), "R11 late row accepted");
    chk(row_ready == 1'b0, $sformatf("R11 ready low after accept act=%0b exp=0", row_ready));

    // R11 valid while not ready is ignored
    row_data = ~lt_row;
    row_valid = 1'b1;
    push("R11 valid ignored when not ready");
    @(negedge clk);
    row_valid = 1'b0;
    @(negedge clk);
    line_step("R11 next line after ignore");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, $sformatf("R11 scoreboard drained act=%0d exp=0", sbq.size()));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule